// File: doc/BRIEF.md
# Low-Speed Clock Source Selector

This block produces the slow timebase for a real-time clock. It has two sources. The first is an internal RC oscillator, which is also the block's own clock `clk`. This path goes through a fixed pre-divider and then a programmable prescaler. The second is an external low-speed crystal oscillator. It arrives as a level on `extOsc`, and the block samples it through a two-stage synchroniser. The block switches between the two sources only at a point where both are low, and it registers the result as `lsClk`. A gated, registered copy appears on `lsOut` for an output pin.

Software controls the block through three registers on a 32-bit single-cycle write bus with a combinational read port:

- **Control register.** It is guarded by a key: a write changes it only when the upper half-word carries the key.
- **Prescaler register.**
- **Output-gate register.**

A silence detector watches the synchronised external signal while the external oscillator is enabled. If the detector sees no edge for `FAIL_LIMIT` cycles, the block forces the internal source back, unless software has set the bypass bit. The forced state is visible when the control register is read back.

Top module: `lsclk_selector`

## Requirements
- R1: A write to offset 0x00 changes the control register only when write bits 31:16 equal 0x16AA; any other key leaves the whole register unchanged.
- R2: Control bit 0 selects the source (1 external, 0 internal), bit 4 enables the external oscillator, and bit 15 bypasses the automatic fallback. A read of offset 0x00 returns these three bits in place with every other bit, including 31:16, as 0.
- R3: Offset 0x08 holds the prescaler N in bits 4:0 and reads back in place. With the internal source selected, `lsClk` has a period of 2·PRE_DIV·(N+1) cycles of `clk`. A write to this offset restarts the divider.
- R4: Offset 0x60 bit 0 is the output gate and reads back in place. When it is set, `lsOut` equals `lsClk` delayed by one cycle. When it is clear, `lsOut` stays 0.
- R5: With the external oscillator enabled, the block declares a failure when the synchronised external input shows no edge for FAIL_LIMIT consecutive cycles. While the failure holds and bypass is clear, the select bit is cleared, which reads back as 0, and `lsClk` returns to the internal divided clock.
- R6: While the bypass bit is set, a silent external oscillator does not change the select bit.
- R7: While the external input keeps toggling, no fallback occurs.
- R8: With the external source active, `lsClk` follows `extOsc` with three cycles of latency. The active source changes only in a cycle after both sources were low, or after a failure.
- R9: After reset the control, prescaler and gate registers read 0 and `lsOut` is 0.
- R10: Writes to unmapped offsets change no register, and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal RC oscillator, also the register clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWe | input | 1 | Write strobe, one cycle per write |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for `busAddr`, combinational |
| extOsc | input | 1 | External low-speed oscillator level |
| lsClk | output | 1 | Selected low-speed clock |
| lsOut | output | 1 | Gated copy of `lsClk` for an output pin |

## Verification
The bench builds the block with PRE_DIV = 4 instead of 32 and keeps FAIL_LIMIT at 64. With the short pre-divider, even the largest prescaler value of 31 gives a period of only 256 cycles, so the bench can measure the periods for the extreme prescaler values directly. With a failure window of 64, the bench can test the silence detector on both sides of the limit, at 30 and at 100 quiet cycles, and both with and without bypass.

// File: rtl/lsc_pkg.sv
package lsc_pkg;
  localparam int PRESC_W = 5;
  localparam logic [15:0] CTRL_KEY = 16'h16AA;
  localparam int unsigned OFS_CTRL  = 32'h00;
  localparam int unsigned OFS_PRESC = 32'h08;
  localparam int unsigned OFS_GATE  = 32'h60;

  // strobes and settings from control to datapath
  typedef struct packed {
    logic               useExt;
    logic               extEn;
    logic               gateEn;
    logic               divRestart;
    logic [PRESC_W-1:0] presc;
  } lscCfg_t;
endpackage

// File: rtl/lsc_ctrl.sv
module lsc_ctrl
  import lsc_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              extFail,
  output lscCfg_t           cfg
);
  logic selExt, extEn, bypass, gateEn;
  logic [PRESC_W-1:0] presc;
  logic selN, enN, bypN;
  logic hitCtrl, hitPresc, hitGate;
  logic keyOk, ctrlUpd;

  assign hitCtrl  = busAddr == ADDR_W'(OFS_CTRL);
  assign hitPresc = busAddr == ADDR_W'(OFS_PRESC);
  assign hitGate  = busAddr == ADDR_W'(OFS_GATE);
  assign keyOk    = busWdata[31:16] == CTRL_KEY;
  assign ctrlUpd  = busWe && hitCtrl && keyOk;

  always_comb begin
    selN = selExt;
    enN  = extEn;
    bypN = bypass;
    if (ctrlUpd) begin
      selN = busWdata[0];
      enN  = busWdata[4];
      bypN = busWdata[15];
    end
    if (extFail && !bypN) selN = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selExt <= 1'b0;
      extEn  <= 1'b0;
      bypass <= 1'b0;
      gateEn <= 1'b0;
      presc  <= '0;
    end else begin
      selExt <= selN;
      extEn  <= enN;
      bypass <= bypN;
      if (busWe && hitGate)  gateEn <= busWdata[0];
      if (busWe && hitPresc) presc  <= busWdata[PRESC_W-1:0];
    end
  end

  always_comb begin
    busRdata = '0;
    if (hitCtrl) begin
      busRdata[0]  = selExt;
      busRdata[4]  = extEn;
      busRdata[15] = bypass;
    end else if (hitPresc) begin
      busRdata[PRESC_W-1:0] = presc;
    end else if (hitGate) begin
      busRdata[0] = gateEn;
    end
  end

  assign cfg.useExt     = selExt;
  assign cfg.extEn      = extEn;
  assign cfg.gateEn     = gateEn;
  assign cfg.divRestart = busWe && hitPresc;
  assign cfg.presc      = presc;

  AST_KEY_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && hitCtrl && !keyOk && !(extFail && !bypass))
      |=> ($stable(selExt) && $stable(extEn) && $stable(bypass))); // R1
  AST_FALLBACK: assert property (@(posedge clk) disable iff (!rstN)
    (extFail && !bypass && !ctrlUpd) |=> !selExt); // R5
  AST_BYPASS_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (bypass && !ctrlUpd) |=> $stable(selExt)); // R6
endmodule

// File: rtl/lsc_divider.sv
module lsc_divider
  import lsc_pkg::*;
#(
  parameter int PRE_DIV = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               restart,
  input  logic [PRESC_W-1:0] presc,
  output logic               intClk
);
  logic preTick;
  logic [PRESC_W-1:0] presCnt;

  generate
    if (PRE_DIV > 1) begin : g_pre
      localparam int PRE_W = $clog2(PRE_DIV);
      logic [PRE_W-1:0] preCnt;
      assign preTick = preCnt == PRE_W'(PRE_DIV - 1);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)        preCnt <= '0;
        else if (restart) preCnt <= '0;
        else if (preTick) preCnt <= '0;
        else              preCnt <= preCnt + 1'b1;
      end
    end else begin : g_nopre
      assign preTick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presCnt <= '0;
      intClk  <= 1'b0;
    end else if (restart) begin
      presCnt <= '0;
      intClk  <= 1'b0;
    end else if (preTick) begin
      if (presCnt == presc) begin
        presCnt <= '0;
        intClk  <= ~intClk;
      end else begin
        presCnt <= presCnt + 1'b1;
      end
    end
  end

  AST_PRES_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    presCnt <= presc); // R3
endmodule

// File: rtl/lsc_datapath.sv
module lsc_datapath
  import lsc_pkg::*;
#(
  parameter int PRE_DIV    = 32,
  parameter int FAIL_LIMIT = 64
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    extOsc,
  input  lscCfg_t cfg,
  output logic    extFail,
  output logic    lsClk,
  output logic    lsOut
);
  localparam int CNT_W = $clog2(FAIL_LIMIT);

  logic extMeta, extSync, extPrev, extEdge;
  logic [CNT_W-1:0] quietCnt;
  logic intClk, actSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      extMeta <= 1'b0;
      extSync <= 1'b0;
      extPrev <= 1'b0;
    end else begin
      extMeta <= extOsc;
      extSync <= extMeta;
      extPrev <= extSync;
    end
  end
  assign extEdge = extSync ^ extPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quietCnt <= '0;
      extFail  <= 1'b0;
    end else if (!cfg.extEn || extEdge) begin
      quietCnt <= '0;
      extFail  <= 1'b0;
    end else if (quietCnt == CNT_W'(FAIL_LIMIT - 1)) begin
      extFail  <= 1'b1;
    end else begin
      quietCnt <= quietCnt + 1'b1;
    end
  end

  lsc_divider #(.PRE_DIV(PRE_DIV)) u_div (
    .clk     (clk),
    .rstN    (rstN),
    .restart (cfg.divRestart),
    .presc   (cfg.presc),
    .intClk  (intClk)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actSel <= 1'b0;
      lsClk  <= 1'b0;
      lsOut  <= 1'b0;
    end else begin
      if (cfg.useExt != actSel && ((!intClk && !extSync) || extFail))
        actSel <= cfg.useExt;
      lsClk <= actSel ? extSync : intClk;
      lsOut <= lsClk & cfg.gateEn;
    end
  end

  AST_SAFE_SWITCH: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(actSel) |-> ($past(!intClk && !extSync) || $past(extFail))); // R8
  AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.gateEn |=> !lsOut); // R4
  AST_EDGE_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    extEdge |=> !extFail); // R7
endmodule

// File: rtl/lsclk_selector.sv
module lsclk_selector
  import lsc_pkg::*;
#(
  parameter int PRE_DIV    = 32,
  parameter int FAIL_LIMIT = 64,
  parameter int ADDR_W     = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              extOsc,
  output logic              lsClk,
  output logic              lsOut
);
  lscCfg_t cfg;
  logic    extFail;

  lsc_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .busWdata (busWdata),
    .busRdata (busRdata),
    .extFail  (extFail),
    .cfg      (cfg)
  );

  lsc_datapath #(.PRE_DIV(PRE_DIV), .FAIL_LIMIT(FAIL_LIMIT)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .extOsc  (extOsc),
    .cfg     (cfg),
    .extFail (extFail),
    .lsClk   (lsClk),
    .lsOut   (lsOut)
  );
endmodule

// File: tb/lsclk_selector_test.sv
module lsclk_selector_test;
  localparam int CLK_P = 10;
  localparam int PRE   = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWe = 1'b0;
  logic [7:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic extOsc = 1'b0;
  logic extRun = 1'b0;
  logic lsClk, lsOut;
  int extCnt = 0;
  int total = 0;
  int fails = 0;
  bit done = 0;

  lsclk_selector #(.PRE_DIV(PRE), .FAIL_LIMIT(64), .ADDR_W(8)) uut (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .extOsc(extOsc),
    .lsClk(lsClk), .lsOut(lsOut)
  );

  always #(CLK_P/2) clk = ~clk;

  // external oscillator model: period of 20 clk cycles while running
  initial begin
    forever begin
      @(negedge clk);
      if (extRun) begin
        extCnt++;
        if (extCnt == 10) begin
          extCnt = 0;
          extOsc = ~extOsc;
        end
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic waitCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measurePeriod(output int per);
    int n = 0;
    do @(negedge clk); while (lsClk !== 1'b0);
    do @(negedge clk); while (lsClk !== 1'b1);
    do begin @(negedge clk); n++; end while (lsClk !== 1'b0);
    do begin @(negedge clk); n++; end while (lsClk !== 1'b1);
    per = n;
  endtask

  task automatic testReset();
    logic [31:0] d;
    busRead(8'h00, d); check("R9 ctrl after reset", d, 32'h0);
    busRead(8'h08, d); check("R9 presc after reset", d, 32'h0);
    busRead(8'h60, d); check("R9 gate after reset", d, 32'h0);
    check("R9 lsOut after reset", {31'b0, lsOut}, 32'h0);
  endtask

  task automatic testPrescaler();
    logic [31:0] d;
    int per;
    busWrite(8'h08, 32'hFFFF_FFE0);
    busRead(8'h08, d); check("R3 presc N=0 readback", d, 32'h0);
    measurePeriod(per); check("R3 period N=0", per, 2*PRE*1);
    busWrite(8'h08, 32'h0000_0005);
    busRead(8'h08, d); check("R3 presc N=5 readback", d, 32'h5);
    measurePeriod(per); check("R3 period N=5", per, 2*PRE*6);
    busWrite(8'h08, 32'h0000_001F);
    measurePeriod(per); check("R3 period N=31", per, 2*PRE*32);
    busWrite(8'h08, 32'h0000_0000);
  endtask

  task automatic testGate();
    logic [31:0] d;
    logic prevLs;
    int bad = 0;
    int highs = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (lsOut !== 1'b0) bad++;
    end
    check("R4 lsOut held low while gate clear", bad, 0);
    busWrite(8'h60, 32'h0000_0001);
    busRead(8'h60, d); check("R4 gate readback", d, 32'h1);
    waitCycles(2);
    bad = 0;
    prevLs = lsClk;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (lsOut !== prevLs) bad++;
      if (lsOut === 1'b1) highs++;
      prevLs = lsClk;
    end
    check("R4 lsOut tracks lsClk one cycle later", bad, 0);
    check("R4 lsOut toggles when gated on", highs > 0, 1);
  endtask

  task automatic testKey();
    logic [31:0] d;
    busWrite(8'h00, 32'h16AA_FFFF);
    busRead(8'h00, d); check("R2 only defined ctrl bits read back", d, 32'h8011);
    busWrite(8'h00, 32'h0000_0000);
    busRead(8'h00, d); check("R1 write without key ignored", d, 32'h8011);
    busWrite(8'h00, 32'h16AB_0000);
    busRead(8'h00, d); check("R1 write with wrong key ignored", d, 32'h8011);
    busWrite(8'h00, 32'h16AA_0000);
    busRead(8'h00, d); check("R1 keyed write clears ctrl", d, 32'h0);
  endtask

  task automatic testUnmapped();
    logic [31:0] d;
    busWrite(8'h04, 32'h16AA_FFFF);
    busRead(8'h04, d); check("R10 unmapped read is zero", d, 32'h0);
    busRead(8'h00, d); check("R10 ctrl unchanged by unmapped write", d, 32'h0);
    busRead(8'h08, d); check("R10 presc unchanged by unmapped write", d, 32'h0);
  endtask

  task automatic testExtFollow();
    logic [31:0] d;
    extRun = 1'b0; extOsc = 1'b0;
    busWrite(8'h00, 32'h16AA_8011);
    waitCycles(12);
    extOsc = 1'b1; waitCycles(6);
    check("R8 lsClk follows external high", {31'b0, lsClk}, 32'h1);
    extOsc = 1'b0; waitCycles(6);
    check("R8 lsClk follows external low", {31'b0, lsClk}, 32'h0);
    extOsc = 1'b1; waitCycles(200);
    busRead(8'h00, d); check("R6 bypass keeps external select", d, 32'h8011);
    check("R6 lsClk still external level", {31'b0, lsClk}, 32'h1);
  endtask

  task automatic testToggleAndFallback();
    logic [31:0] d;
    int per;
    extCnt = 0; extRun = 1'b1;
    waitCycles(30);
    busWrite(8'h08, 32'h0000_0002);
    busWrite(8'h00, 32'h16AA_0011);
    waitCycles(300);
    busRead(8'h00, d); check("R7 no fallback while external toggles", d, 32'h11);
    measurePeriod(per); check("R8 lsClk period matches external", per, 20);
    extRun = 1'b0; extOsc = 1'b0;
    waitCycles(30);
    busRead(8'h00, d); check("R5 no fallback before limit", d, 32'h11);
    waitCycles(70);
    busRead(8'h00, d); check("R5 fallback clears select", d, 32'h10);
    measurePeriod(per); check("R5 lsClk back on internal", per, 2*PRE*3);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      fails++; total++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    waitCycles(5);
    rstN = 1'b1;
    testReset();
    testPrescaler();
    testGate();
    testKey();
    testUnmapped();
    testExtFollow();
    testToggleAndFallback();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule